// File: doc/BRIEF.md
# Bit-Serial Clock-Chip Command Engine

This block is the slave side of a two-wire serial link to a clock chip. The host presents one data bit per bit strobe on `sdi` and reads one bit back from `sdo`. A transaction is sixteen bit slots. The first eight slots carry a command byte, most significant bit first. Depending on the command, the remaining eight slots then carry either a write byte in from the host or a read byte out to the host, again most significant bit first.

Behind the link sit three things: a 32-byte battery-backed RAM, a status byte and a constant control byte. The engine does not keep real time. An external counter supplies the current time of day in binary on a parallel port, and the engine converts the requested field to BCD when a time command is decoded. A power-event interrupt line is raised out of reset. Software clears it with a dedicated write command, which also clears the matching status bits. The host pulses `abort` before every transaction, and may also use it to cancel one.

Top module: `rtc_serial_slave`

## Requirements
- R1: Each `bit_stb` pulse (one `clk` cycle wide) consumes `sdi`. During slots 0–7 the bit enters the command register at its LSB, so the first bit sent becomes the command MSB. A command is a write when it lies in 0x80–0x9F or equals 0xB1; every other command is a read.
- R2: For a read command, the return byte is latched at the strobe of slot 7. The strobes of slots 8 through 15 then put its bits on `sdo`, bit 7 first. `sdo` changes only on the clock edge that takes a strobe and holds its value between strobes.
- R3: Read commands 0x00–0x1F return RAM byte [command]. Write commands 0x80–0x9F store the eight data bits, first bit as MSB, into RAM byte [command − 0x80] at the strobe of slot 15.
- R4: Read commands 0x20–0x2F return time fields in packed BCD (tens in bits 7:4, units in bits 3:0): 0x20 seconds, 0x21 minutes, 0x22 hours, 0x24 day of month, 0x25 month (1–12), 0x26 year (0–99). Codes 0x23 and 0x27–0x2F return 0x00.
- R5: Command 0x30 returns the status byte and command 0x31 returns the control byte, which is the parameter `CTRL_VALUE` (default 0x00).
- R6: When a write with command 0xB1 completes and data bit 2 (0x04) is set, status bits 4 and 3 are cleared and `pwr_irq` drops to 0. The other status bits never change. Without data bit 2 the write has no effect. `pwr_irq` never rises except through reset.
- R7: `abort` clears the slot counter, the command register and the data register. It takes priority over a strobe in the same cycle. A write cut short by `abort` changes nothing.
- R8: After reset the following hold: status = 0x90, `pwr_irq` = 1, `sdo` = 0, and RAM byte i = `RAM_SEED` XOR (29·i mod 256), with `RAM_SEED` defaulting to 0x3C.
- R9: Strobes after slot 15 are ignored until the next `abort`. They write nothing again and leave `sdo` unchanged.
- R10: Read commands outside the ranges above return 0x00. During a write command, `sdo` keeps the value it had before the transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_stb | input | 1 | One-cycle strobe: one serial bit slot |
| sdi | input | 1 | Serial data from host |
| abort | input | 1 | Command reset / transaction abort |
| tod_sec | input | 6 | Seconds, binary 0–59 |
| tod_min | input | 6 | Minutes, binary 0–59 |
| tod_hour | input | 5 | Hours, binary 0–23 |
| tod_mday | input | 5 | Day of month, binary 1–31 |
| tod_mon | input | 4 | Month, binary 1–12 |
| tod_year | input | 7 | Year within century, binary 0–99 |
| sdo | output | 1 | Serial data to host |
| pwr_irq | output | 1 | Power-event interrupt, active high |

## Verification
The bench sweeps all 256 command codes through complete transactions and compares each result against an arithmetic model. A design with a wrong write-range decode would either echo data or corrupt RAM; a sweep of this kind exposes both, and it also catches a late or early latch of the return byte, which would shift every read by one bit. Time fields are read across sixty distinct time sets. This catches a BCD converter that fails at the units-to-tens carry, as well as a swapped field code. Further directed cases cover the rest: 0xB1 without bit 2, which a careless design would treat as a clear; a write aborted after four data bits, which a design committing early would store; and extra strobes after slot 15, which a wrapping counter would treat as a new command.

// File: rtl/rtc_serial_slave.sv
`timescale 1ns/1ps
module rtc_serial_slave #(
  parameter logic [7:0] RAM_SEED    = 8'h3C,
  parameter logic [7:0] STATUS_INIT = 8'h90,
  parameter logic [7:0] CTRL_VALUE  = 8'h00
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_stb,
  input  logic       sdi,
  input  logic       abort,
  input  logic [5:0] tod_sec,
  input  logic [5:0] tod_min,
  input  logic [4:0] tod_hour,
  input  logic [4:0] tod_mday,
  input  logic [3:0] tod_mon,
  input  logic [6:0] tod_year,
  output logic       sdo,
  output logic       pwr_irq
);
  localparam int RAM_BYTES = 32;
  localparam int SLOTS     = 16;
  localparam int SW        = $clog2(SLOTS + 1);

  logic [SW-1:0] slot;
  logic [7:0]    cmd, wdat, retval, status;
  logic [7:0]    ram [RAM_BYTES];

  function automatic logic is_wr(input logic [7:0] c);
    return (c[7:5] == 3'b100) || (c == 8'hB1);
  endfunction

  function automatic logic [7:0] to_bcd(input logic [6:0] v);
    logic [6:0] t, u;
    t = v / 7'd10;
    u = v - t * 7'd10;
    return {t[3:0], u[3:0]};
  endfunction

  function automatic logic [7:0] rd_val(input logic [7:0] c);
    logic [7:0] r;
    r = 8'h00;
    if (c[7:5] == 3'b000) r = ram[c[4:0]];
    else case (c)
      8'h20: r = to_bcd({1'b0, tod_sec});
      8'h21: r = to_bcd({1'b0, tod_min});
      8'h22: r = to_bcd({2'b0, tod_hour});
      8'h24: r = to_bcd({2'b0, tod_mday});
      8'h25: r = to_bcd({3'b0, tod_mon});
      8'h26: r = to_bcd(tod_year);
      8'h30: r = status;
      8'h31: r = CTRL_VALUE;
      default: r = 8'h00;
    endcase
    return r;
  endfunction

  wire [7:0] cmd_nx  = {cmd[6:0], sdi};
  wire [7:0] wdat_nx = {wdat[6:0], sdi};
  wire       live    = bit_stb && (slot != SW'(SLOTS));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot    <= '0;
      cmd     <= '0;
      wdat    <= '0;
      retval  <= '0;
      sdo     <= 1'b0;
      status  <= STATUS_INIT;
      pwr_irq <= 1'b1;
      for (int i = 0; i < RAM_BYTES; i++)
        ram[i] <= RAM_SEED ^ 8'(i * 29);
    end else if (abort) begin
      slot <= '0;
      cmd  <= '0;
      wdat <= '0;
    end else if (live) begin
      slot <= slot + 1'b1;
      if (!slot[3]) begin
        cmd <= cmd_nx;
        if (slot[2:0] == 3'd7 && !is_wr(cmd_nx)) retval <= rd_val(cmd_nx);
      end else if (is_wr(cmd)) begin
        wdat <= wdat_nx;
        if (slot[2:0] == 3'd7) begin
          if (cmd[7:5] == 3'b100) ram[cmd[4:0]] <= wdat_nx;
          if (cmd == 8'hB1 && wdat_nx[2]) begin
            status  <= status & ~8'h18;
            pwr_irq <= 1'b0;
          end
        end
      end else begin
        sdo <= retval[~slot[2:0]];
      end
    end
  end
endmodule

module rtc_serial_slave_chk #(parameter int SW = 5) (
  input logic          clk,
  input logic          rst_n,
  input logic          bit_stb,
  input logic          abort,
  input logic          sdo,
  input logic          pwr_irq,
  input logic [SW-1:0] slot,
  input logic [7:0]    cmd,
  input logic [7:0]    status
);
  // R9
  slot_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slot == SW'(16) && !abort) |=> slot == SW'(16));
  // R7
  abort_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (slot == '0 && cmd == 8'h00));
  // R2
  sdo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_stb |=> $stable(sdo));
  // R6
  irq_no_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(pwr_irq));
  // R6
  status_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(status & 8'hE7));
  // R6
  irq_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_irq == ((status & 8'h18) != 8'h00));
endmodule

bind rtc_serial_slave rtc_serial_slave_chk #(.SW(SW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .abort(abort), .sdo(sdo),
  .pwr_irq(pwr_irq), .slot(slot), .cmd(cmd), .status(status));

// File: tb/test_rtc_serial_slave.sv
`timescale 1ns/1ps
module test_rtc_serial_slave;
  logic clk = 0, rst_n = 0, bit_stb = 0, sdi = 0, abort = 0;
  logic [5:0] tod_sec = 0, tod_min = 0;
  logic [4:0] tod_hour = 0, tod_mday = 1;
  logic [3:0] tod_mon = 1;
  logic [6:0] tod_year = 0;
  logic sdo, pwr_irq;
  int total = 0, bad = 0;
  bit done = 0;
  logic [7:0] m_ram [32];
  logic [7:0] m_status;

  always #4 clk = ~clk;

  rtc_serial_slave i_rtc_serial_slave (.*);

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic int bcd(input int v);
    return (v / 10) * 16 + v % 10;
  endfunction

  function automatic logic m_is_wr(input logic [7:0] c);
    return (c >= 8'h80 && c <= 8'h9F) || c == 8'hB1;
  endfunction

  function automatic logic [7:0] m_read(input logic [7:0] c);
    if (c <= 8'h1F) return m_ram[c[4:0]];
    case (c)
      8'h20: return 8'(bcd(tod_sec));
      8'h21: return 8'(bcd(tod_min));
      8'h22: return 8'(bcd(tod_hour));
      8'h24: return 8'(bcd(tod_mday));
      8'h25: return 8'(bcd(tod_mon));
      8'h26: return 8'(bcd(tod_year));
      8'h30: return m_status;
      8'h31: return 8'h00;
      default: return 8'h00;
    endcase
  endfunction

  task automatic m_write(input logic [7:0] c, input logic [7:0] d);
    if (c >= 8'h80 && c <= 8'h9F) m_ram[c[4:0]] = d;
    if (c == 8'hB1 && d[2]) m_status = m_status & 8'hE7;
  endtask

  task automatic strobe(input logic b);
    @(negedge clk); sdi = b; bit_stb = 1;
    @(negedge clk); bit_stb = 0;
  endtask

  task automatic do_abort();
    @(negedge clk); abort = 1;
    @(negedge clk); abort = 0;
  endtask

  // full transaction; returns the byte seen on sdo during slots 8..15
  task automatic xfer(input logic [7:0] c, input logic [7:0] d, output logic [7:0] r);
    do_abort();
    for (int i = 7; i >= 0; i--) strobe(c[i]);
    for (int i = 7; i >= 0; i--) begin
      strobe(d[i]);
      r[i] = sdo;
    end
  endtask

  initial begin
    logic [7:0] r, held;
    for (int i = 0; i < 32; i++) m_ram[i] = 8'h3C ^ 8'(i * 29);
    m_status = 8'h90;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R8 reset state
    chk("R8 sdo", sdo, 0);
    chk("R8 pwr_irq", pwr_irq, 1);
    xfer(8'h30, 8'h00, r); chk("R8 status", r, 8'h90);
    xfer(8'h31, 8'h00, r); chk("R5 control", r, 8'h00);
    for (int i = 0; i < 32; i++) begin
      xfer(8'(i), 8'h00, r); chk("R8 ram image", r, m_ram[i]);
    end
    // R6 0xB1 without bit 2 has no effect
    xfer(8'hB1, 8'hFB, r);
    chk("R6 no-clear irq", pwr_irq, 1);
    xfer(8'h30, 8'h00, r); chk("R6 no-clear status", r, 8'h90);
    // R7 write aborted after four data bits
    do_abort();
    for (int i = 7; i >= 0; i--) strobe(1'(8'h86 >> i));
    for (int i = 0; i < 4; i++) strobe(1'b1);
    xfer(8'h06, 8'h00, r); chk("R7 aborted write", r, m_ram[6]);
    // R7 garbage bits then a fresh read
    do_abort();
    strobe(1); strobe(0); strobe(1);
    do_abort();
    for (int i = 7; i >= 0; i--) strobe(1'(8'h31 >> i));
    for (int i = 7; i >= 0; i--) begin strobe(0); r[i] = sdo; end
    chk("R7 fresh after abort", r, 8'h00);
    // R9 strobes beyond slot 15
    xfer(8'h85, 8'h3C, r); m_write(8'h85, 8'h3C);
    held = sdo;
    for (int i = 0; i < 6; i++) strobe(1'b1);
    chk("R9 sdo held", sdo, held);
    xfer(8'h05, 8'h00, r); chk("R9 single write", r, 8'h3C);
    held = sdo;
    for (int i = 0; i < 8; i++) strobe(1'(i));
    chk("R9 sdo after extra", sdo, held);
    // R4 time fields across many values
    for (int k = 0; k < 60; k++) begin
      tod_sec = 6'(k); tod_min = 6'((k * 7) % 60); tod_hour = 5'(k % 24);
      tod_mday = 5'(k % 31 + 1); tod_mon = 4'(k % 12 + 1); tod_year = 7'((k * 17) % 100);
      xfer(8'h20, 0, r); chk("R4 sec", r, bcd(tod_sec));
      xfer(8'h21, 0, r); chk("R4 min", r, bcd(tod_min));
      xfer(8'h22, 0, r); chk("R4 hour", r, bcd(tod_hour));
      xfer(8'h24, 0, r); chk("R4 mday", r, bcd(tod_mday));
      xfer(8'h25, 0, r); chk("R4 mon", r, bcd(tod_mon));
      xfer(8'h26, 0, r); chk("R4 year", r, bcd(tod_year));
    end
    // R1 R2 R3 R5 R6 R10 sweep of every command code
    for (int c = 0; c < 256; c++) begin
      held = sdo;
      xfer(8'(c), 8'(c) ^ 8'hA5, r);
      if (m_is_wr(8'(c))) begin
        chk("R10 write keeps sdo", r, {8{held}});
        m_write(8'(c), 8'(c) ^ 8'hA5);
      end else begin
        chk("R1 R2 read sweep", r, m_read(8'(c)));
      end
    end
    // R6 after 0xB1 with 0x14 (bit 2 set) in the sweep
    chk("R6 irq cleared", pwr_irq, 0);
    xfer(8'h30, 8'h00, r); chk("R6 status cleared", r, 8'h80);
    for (int i = 0; i < 32; i++) begin
      xfer(8'(i), 8'h00, r); chk("R3 ram readback", r, m_ram[i]);
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 180000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule